// File: doc/BRIEF.md
# Parallel flash command interface

This block models a parallel NOR flash behind a simple synchronous bus. The storage is a small internal byte array. Writes to the block are not stored directly. A command state machine reads the low byte of each write as a command code. That code decides whether the next writes store data, erase a sector, change lock state or start a counted burst. The same command state decides what a read returns: the array contents, the status byte or a byte of the built-in parameter table.

Every operation finishes in the cycle its last bus write is taken. The status byte then shows the ready flag in bit 7. There is no program or erase delay, no interleaving, no suspend and no real protection. The port width is a parameter of 1, 2 or 4 bytes. Multi-byte words are little-endian, with the lowest address in bits 7:0. Word addresses are aligned by ignoring the low address bits below the port width.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, `bus_rdata` is 0, all storage bytes read as 0xFF, the status byte is 0x00, and reads return array data.
- R2: A read strobe loads `bus_rdata` at the next clock edge and the value is held while the strobe is low. A read in the same cycle as a write returns what the state was before that write. An array read returns the aligned word in little-endian order.
- R3: In idle, a write of 0x10 or 0x40 arms program. The next write stores its full data word at its aligned address, sets status bit 7 and returns to idle.
- R4: In idle, 0x20 arms sector erase. A following 0xD0 fills every byte of the sector holding the confirm address with 0xFF (sector base = address with the low SECTOR_W bits cleared) and sets status bit 7. Any other second byte, 0xFF included, erases nothing and returns to array read.
- R5: In idle, 0x50 writes status 0x00 and returns to array read. 0x70 makes later reads return the status byte, zero-extended to the port width.
- R6: In idle, 0x60 arms lock/unlock. A second byte of 0xD0 or 0x01 sets status bit 7. Any other second byte returns to array read.
- R7: In idle, 0xE8 sets status bit 7. The next write gives a count N (low byte). The next N+1 writes store data words at their own addresses. The write after those is the confirm: 0xD0 ends in idle, any other value stores nothing and returns to array read.
- R8: In idle, 0x98 enters query mode. Reads return the table byte at index = address bits 7:0 shifted right by log2(PORT_BYTES). Indices at or above TABLE_LEN return 0. Writes other than 0xFF stay in query mode, and 0xFF leaves it to array read.
- R9: Table contents: 0x10..0x12 = 0x51, 0x52, 0x59; 0x13 = 0x01; 0x27 = ADDR_W; 0x2C = 0x01; 0x2D/0x2E = sector count − 1, as a 16-bit value with the low byte first; 0x2F/0x30 = sector bytes ÷ 256, as a 16-bit value with the low byte first. All other indices read 0.
- R10: In idle, 0xFF, 0x00 or any unlisted code returns reads to array data with no other effect.
- R11: While program, erase, lock or a burst is pending, and in idle after a completed program, erase, lock or burst, reads return the status byte until a command changes the read source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8*PORT_BYTES | Write data; bits 7:0 carry commands |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8*PORT_BYTES | Registered read data |

## Verification
A read and a command write can fall in the same cycle. In that case the read must reflect the read source and array contents as they were before the write. The bench provokes this by raising both strobes together while a 0x70 command moves the source from array to status. The returned word must still be the array value, and the read that follows must be the status. Every clock is compared against a behavioural model that evaluates the read before applying the write.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes, state encoding and read-source selector for the
// flash command interface. Assumes 8-bit command bytes.
package flash_cmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_ERASE, ST_LOCK,
        ST_QUERY, ST_BUF_CNT, ST_BUF_DATA, ST_BUF_CONF
    } fsm_state_t;

    typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_QUERY} rd_src_t;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CLR      = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STAT     = 8'h70;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUF      = 8'hE8;
    localparam logic [7:0] OP_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;
    localparam logic [7:0] READY_BIT   = 8'h80;
endpackage

// File: rtl/flash_cmd_fsm.sv
// Command sequencer: decodes command bytes from bus writes, tracks the
// multi-cycle sequences and the status byte, and selects the read source.
// Assumes at most one write per cycle; every operation completes at once.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] cmd_byte,
    output rd_src_t    rd_src,
    output logic [7:0] status,
    output logic       store_word,
    output logic       erase_sector
);
    fsm_state_t state;
    logic       show_status;
    logic [7:0] beats;

    // Data stores happen on program data and burst data beats.
    assign store_word   = wr_en && (state == ST_PROG || state == ST_BUF_DATA);
    // Erase happens on the confirm cycle of a sector erase.
    assign erase_sector = wr_en && (state == ST_ERASE) && (cmd_byte == OP_CONFIRM);

    // Read source follows the command state.
    always_comb begin
        if (state == ST_QUERY)
            rd_src = SRC_QUERY;
        else if (state == ST_IDLE && !show_status)
            rd_src = SRC_ARRAY;
        else
            rd_src = SRC_STATUS;
    end

    // Sequence state, status byte and burst beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            show_status <= 1'b0;
            status      <= 8'h00;
            beats       <= 8'h00;
        end else if (wr_en) begin
            case (state)
                ST_IDLE: begin
                    case (cmd_byte)
                        OP_PROG_A, OP_PROG_B: state <= ST_PROG;
                        OP_ERASE: state <= ST_ERASE;
                        OP_LOCK:  state <= ST_LOCK;
                        OP_QUERY: state <= ST_QUERY;
                        OP_CLR: begin
                            status      <= 8'h00;
                            show_status <= 1'b0;
                        end
                        OP_STAT: show_status <= 1'b1;
                        OP_BUF: begin
                            state  <= ST_BUF_CNT;
                            status <= status | READY_BIT;
                        end
                        default: show_status <= 1'b0;
                    endcase
                end
                ST_PROG: begin
                    state       <= ST_IDLE;
                    status      <= status | READY_BIT;
                    show_status <= 1'b1;
                end
                ST_ERASE, ST_LOCK, ST_BUF_CONF: begin
                    state <= ST_IDLE;
                    if (cmd_byte == OP_CONFIRM ||
                        (state == ST_LOCK && cmd_byte == OP_LOCK_ALT)) begin
                        status      <= status | READY_BIT;
                        show_status <= 1'b1;
                    end else begin
                        show_status <= 1'b0;
                    end
                end
                ST_QUERY: begin
                    if (cmd_byte == OP_ARRAY) begin
                        state       <= ST_IDLE;
                        show_status <= 1'b0;
                    end
                end
                ST_BUF_CNT: begin
                    beats <= cmd_byte;
                    state <= ST_BUF_DATA;
                end
                ST_BUF_DATA: begin
                    status <= status | READY_BIT;
                    if (beats == 8'h00)
                        state <= ST_BUF_CONF;
                    else
                        beats <= beats - 8'h01;
                end
                default: begin
                    state       <= ST_IDLE;
                    show_status <= 1'b0;
                end
            endcase
        end
    end

    // R3: a program data write completes at once with ready set
    assert_prog_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_PROG) |=> (state == ST_IDLE && status[7]));

    // R5: clear status zeroes the status byte and shows the array
    assert_clear_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_IDLE && cmd_byte == OP_CLR)
        |=> (status == 8'h00 && rd_src == SRC_ARRAY));

    // R7: the last burst beat leads to the confirm cycle
    assert_burst_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_BUF_DATA && beats == 8'h00) |=> (state == ST_BUF_CONF));

    // R8: non-exit writes keep query mode
    assert_query_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_QUERY && cmd_byte != OP_ARRAY) |=> (rd_src == SRC_QUERY));

    // R10: a return-to-array code in idle shows the array next
    assert_array_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_IDLE && (cmd_byte == OP_ARRAY || cmd_byte == 8'h00))
        |=> (rd_src == SRC_ARRAY));
endmodule

// File: rtl/flash_store.sv
// Byte-array storage: word write at an aligned address and single-cycle
// sector fill with 0xFF. Assumes erase and word store never coincide.
// Read is combinational on the aligned word address.
module flash_store #(
    parameter int ADDR_W     = 10,
    parameter int SECTOR_W   = 8,
    parameter int PORT_BYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_word,
    input  logic                    erase,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [8*PORT_BYTES-1:0] wdata,
    output logic [8*PORT_BYTES-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(PORT_BYTES - 1);

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] base;

    assign base = addr & ~LANE_MASK;

    // Gather the little-endian word at the aligned address.
    always_comb begin
        for (int k = 0; k < PORT_BYTES; k++)
            rd_word[8*k +: 8] = mem[base + ADDR_W'(k)];
    end

    // Reset to erased, sector fill, or word store per byte.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= 8'hFF;
            else if (erase &&
                     ADDR_W'(i) >> SECTOR_W == addr >> SECTOR_W)
                mem[i] <= 8'hFF;
            else if (wr_word && (ADDR_W'(i) & ~LANE_MASK) == base)
                mem[i] <= wdata[8*(i % PORT_BYTES) +: 8];
        end
    end

    // R4: after an erase the confirm address reads as erased
    assert_erase_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem[$past(addr)] == 8'hFF));
endmodule

// File: rtl/flash_query_rom.sv
// Parameter table: computes the query byte for an index from the geometry
// parameters. Assumes ADDR_W > SECTOR_W.
module flash_query_rom #(
    parameter int ADDR_W    = 10,
    parameter int SECTOR_W  = 8,
    parameter int TABLE_LEN = 64
) (
    input  logic [7:0] index,
    output logic [7:0] value
);
    localparam int BLK_M1   = (1 << (ADDR_W - SECTOR_W)) - 1;
    localparam int SECT_DIV = (1 << SECTOR_W) >> 8;

    // Map index to table byte; out-of-range returns zero.
    always_comb begin
        value = 8'h00;
        if (int'(index) < TABLE_LEN) begin
            case (index)
                8'h10: value = 8'h51;
                8'h11: value = 8'h52;
                8'h12: value = 8'h59;
                8'h13: value = 8'h01;
                8'h27: value = 8'(ADDR_W);
                8'h2C: value = 8'h01;
                8'h2D: value = 8'(BLK_M1);
                8'h2E: value = 8'(BLK_M1 >> 8);
                8'h2F: value = 8'(SECT_DIV);
                8'h30: value = 8'(SECT_DIV >> 8);
                default: value = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_if.sv
// Top: parallel flash command interface. Joins sequencer, storage and
// parameter table, and registers read data from the selected source.
// Assumes PORT_BYTES is 1, 2 or 4 and ADDR_W >= 8.
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SECTOR_W   = 8,
    parameter int PORT_BYTES = 2,
    parameter int TABLE_LEN  = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [8*PORT_BYTES-1:0] bus_wdata,
    input  logic                    bus_we,
    input  logic                    bus_re,
    output logic [8*PORT_BYTES-1:0] bus_rdata
);
    localparam int DW    = 8 * PORT_BYTES;
    localparam int SHIFT = $clog2(PORT_BYTES);

    rd_src_t       rd_src;
    logic [7:0]    status;
    logic          store_word;
    logic          erase_sector;
    logic [DW-1:0] arr_word;
    logic [7:0]    q_index;
    logic [7:0]    q_byte;

    assign q_index = bus_addr[7:0] >> SHIFT;

    flash_cmd_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_we),
        .cmd_byte     (bus_wdata[7:0]),
        .rd_src       (rd_src),
        .status       (status),
        .store_word   (store_word),
        .erase_sector (erase_sector)
    );

    flash_store #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .PORT_BYTES(PORT_BYTES)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_word (store_word),
        .erase   (erase_sector),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rd_word (arr_word)
    );

    flash_query_rom #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .TABLE_LEN(TABLE_LEN)) i_rom (
        .index (q_index),
        .value (q_byte)
    );

    // Register read data from the source selected before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re) begin
            case (rd_src)
                SRC_ARRAY:  bus_rdata <= arr_word;
                SRC_STATUS: bus_rdata <= DW'(status);
                SRC_QUERY:  bus_rdata <= DW'(q_byte);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // R2: read data holds while no read is requested
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/test_flash_cmd_if.sv
// Bench: behavioural reference model compared on every clock, plus
// explicit checks against values taken from the requirements.
module test_flash_cmd_if;
    localparam int AW = 10;
    localparam int PB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [15:0]   bus_rdata;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] mmem [0:1023];
    int         ms;
    bit         mshow;
    logic [7:0] mstat;
    int         mbeats;
    logic [15:0] exp_rd;

    always #10 clk = ~clk;

    flash_cmd_if #(.ADDR_W(AW), .SECTOR_W(8), .PORT_BYTES(PB), .TABLE_LEN(64)) i_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata));

    function automatic logic [7:0] qtab(input logic [7:0] idx);
        case (idx)
            8'h10: return 8'h51;
            8'h11: return 8'h52;
            8'h12: return 8'h59;
            8'h13: return 8'h01;
            8'h27: return 8'd10;
            8'h2C: return 8'h01;
            8'h2D: return 8'h03;
            8'h2F: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] mread(input logic [AW-1:0] a);
        int al;
        al = int'(a) & ~1;
        if (ms == 4) return {8'h00, qtab(a[7:0] >> 1)};
        if (ms == 0 && !mshow) return {mmem[al+1], mmem[al]};
        return {8'h00, mstat};
    endfunction

    task automatic mstore(input logic [AW-1:0] a, input logic [15:0] d);
        int al;
        al = int'(a) & ~1;
        mmem[al] = d[7:0];
        mmem[al+1] = d[15:8];
    endtask

    task automatic mwrite(input logic [AW-1:0] a, input logic [15:0] d);
        logic [7:0] c;
        c = d[7:0];
        case (ms)
            0: case (c)
                8'h10, 8'h40: ms = 1;
                8'h20: ms = 2;
                8'h60: ms = 3;
                8'h98: ms = 4;
                8'h50: begin mstat = 0; mshow = 0; end
                8'h70: mshow = 1;
                8'hE8: begin ms = 5; mstat = 8'h80; end
                default: mshow = 0;
            endcase
            1: begin mstore(a, d); mstat = 8'h80; mshow = 1; ms = 0; end
            2: begin
                ms = 0;
                if (c == 8'hD0) begin
                    for (int i = 0; i < 256; i++) mmem[(int'(a) & 'h300) + i] = 8'hFF;
                    mstat = 8'h80; mshow = 1;
                end else mshow = 0;
            end
            3: begin
                ms = 0;
                if (c == 8'hD0 || c == 8'h01) begin mstat = 8'h80; mshow = 1; end
                else mshow = 0;
            end
            4: if (c == 8'hFF) begin ms = 0; mshow = 0; end
            5: begin mbeats = int'(c); ms = 6; end
            6: begin
                mstore(a, d); mstat = 8'h80;
                if (mbeats == 0) ms = 7; else mbeats--;
            end
            default: begin
                ms = 0;
                if (c == 8'hD0) begin mstat = 8'h80; mshow = 1; end
                else mshow = 0;
            end
        endcase
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string req);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // One bus cycle: inputs at a falling edge, compare at the next one.
    task automatic step(input bit we, input bit re, input logic [AW-1:0] a,
                        input logic [15:0] d, input string req);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
        if (re) exp_rd = mread(a);
        if (we) mwrite(a, d);
        @(negedge clk);
        bus_we = 0; bus_re = 0;
        chk(bus_rdata, exp_rd, req);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input string req);
        step(1, 0, a, d, req);
    endtask

    task automatic rdc(input logic [AW-1:0] a, input logic [15:0] v, input string req);
        step(0, 1, a, 16'h0, req);
        chk(bus_rdata, v, req);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
        wr(a, 16'h0040, "R3");
        wr(a, d, "R3");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mmem[i] = 8'hFF;
        ms = 0; mshow = 0; mstat = 0; mbeats = 0; exp_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(bus_rdata, 16'h0000, "R1");
        rdc(10'h000, 16'hFFFF, "R1");
        wr(10'h000, 16'h0070, "R1");
        rdc(10'h000, 16'h0000, "R1");
        wr(10'h000, 16'h00FF, "R1");

        // program with both codes
        prog(10'h010, 16'hA55A);
        rdc(10'h010, 16'h0080, "R11");
        wr(10'h000, 16'h00FF, "R10");
        rdc(10'h010, 16'hA55A, "R3");
        rdc(10'h011, 16'hA55A, "R2");
        wr(10'h012, 16'h0010, "R3");
        wr(10'h012, 16'h1234, "R3");
        wr(10'h000, 16'h00FF, "R3");
        rdc(10'h012, 16'h1234, "R3");
        rdc(10'h013, 16'h1234, "R2");

        // read and command write together
        step(1, 1, 10'h010, 16'h0070, "R2");
        chk(bus_rdata, 16'hA55A, "R2");
        rdc(10'h010, 16'h0080, "R5");
        wr(10'h000, 16'h0050, "R5");
        rdc(10'h010, 16'hA55A, "R5");
        wr(10'h000, 16'h0070, "R5");
        rdc(10'h010, 16'h0000, "R5");
        wr(10'h000, 16'h00FF, "R5");

        // sector erase
        prog(10'h100, 16'hBEEF);
        prog(10'h1FE, 16'hCAFE);
        prog(10'h200, 16'h0F0F);
        prog(10'h0FE, 16'h1111);
        wr(10'h000, 16'h0050, "R5");
        wr(10'h105, 16'h0020, "R4");
        rdc(10'h105, 16'h0000, "R11");
        wr(10'h105, 16'h00D0, "R4");
        rdc(10'h105, 16'h0080, "R4");
        wr(10'h000, 16'h00FF, "R4");
        rdc(10'h100, 16'hFFFF, "R4");
        rdc(10'h1FE, 16'hFFFF, "R4");
        rdc(10'h200, 16'h0F0F, "R4");
        rdc(10'h0FE, 16'h1111, "R4");
        wr(10'h010, 16'h0020, "R4");
        wr(10'h010, 16'h00FF, "R4");
        rdc(10'h010, 16'hA55A, "R4");
        wr(10'h010, 16'h0020, "R4");
        wr(10'h010, 16'h0033, "R4");
        rdc(10'h010, 16'hA55A, "R4");

        // lock and unlock
        wr(10'h000, 16'h0050, "R6");
        wr(10'h000, 16'h0060, "R6");
        wr(10'h000, 16'h0001, "R6");
        rdc(10'h000, 16'h0080, "R6");
        wr(10'h000, 16'h0050, "R6");
        wr(10'h000, 16'h0060, "R6");
        wr(10'h000, 16'h00D0, "R6");
        rdc(10'h000, 16'h0080, "R6");
        wr(10'h000, 16'h0050, "R6");
        wr(10'h000, 16'h0060, "R6");
        wr(10'h010, 16'h0077, "R6");
        rdc(10'h010, 16'hA55A, "R6");

        // buffered write, N = 3
        wr(10'h000, 16'h0050, "R7");
        wr(10'h300, 16'h00E8, "R7");
        rdc(10'h300, 16'h0080, "R7");
        wr(10'h300, 16'h0003, "R7");
        wr(10'h300, 16'h1111, "R7");
        wr(10'h302, 16'h2222, "R7");
        wr(10'h304, 16'h3333, "R7");
        wr(10'h306, 16'h4444, "R7");
        rdc(10'h306, 16'h0080, "R11");
        wr(10'h300, 16'h00D0, "R7");
        rdc(10'h300, 16'h0080, "R7");
        wr(10'h000, 16'h00FF, "R7");
        rdc(10'h300, 16'h1111, "R7");
        rdc(10'h302, 16'h2222, "R7");
        rdc(10'h304, 16'h3333, "R7");
        rdc(10'h306, 16'h4444, "R7");
        rdc(10'h308, 16'hFFFF, "R7");
        // N = 1, then a bad confirm
        wr(10'h310, 16'h00E8, "R7");
        wr(10'h310, 16'h0001, "R7");
        wr(10'h310, 16'hAAAA, "R7");
        wr(10'h312, 16'hBBBB, "R7");
        wr(10'h314, 16'hCCCC, "R7");
        rdc(10'h314, 16'hFFFF, "R7");
        rdc(10'h312, 16'hBBBB, "R7");

        // query mode
        wr(10'h000, 16'h0098, "R8");
        rdc(10'h020, 16'h0051, "R9");
        rdc(10'h022, 16'h0052, "R9");
        rdc(10'h024, 16'h0059, "R9");
        rdc(10'h026, 16'h0001, "R9");
        rdc(10'h04E, 16'h000A, "R9");
        rdc(10'h058, 16'h0001, "R9");
        rdc(10'h05A, 16'h0003, "R9");
        rdc(10'h05C, 16'h0000, "R9");
        rdc(10'h05E, 16'h0001, "R9");
        rdc(10'h060, 16'h0000, "R9");
        rdc(10'h021, 16'h0051, "R8");
        rdc(10'h120, 16'h0051, "R8");
        rdc(10'h090, 16'h0000, "R8");
        wr(10'h000, 16'h0055, "R8");
        rdc(10'h020, 16'h0051, "R8");
        wr(10'h000, 16'h00FF, "R8");
        rdc(10'h020, 16'hFFFF, "R8");

        // unknown and zero codes
        wr(10'h000, 16'h0070, "R10");
        wr(10'h000, 16'h0033, "R10");
        rdc(10'h010, 16'hA55A, "R10");
        wr(10'h000, 16'h0070, "R10");
        wr(10'h000, 16'h0000, "R10");
        rdc(10'h010, 16'hA55A, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule